// File: doc/BRIEF.md
# Smart Card Receive Bit Sampler

This block is the receive front end of a half-duplex smart card serial link. It runs from a basic-clock enable (`tick`) that pulses at a fixed multiple of the bit rate, and the multiple is chosen by a 2-bit select. The serial line goes through a synchronizer. While the receiver is idle, a falling edge on the synchronized line marks a start bit and restarts the bit-phase counter.

Each bit is then taken at the middle of its period: on the tick where the phase counter reaches half the ratio minus one. Ten bits are collected per character: one start bit, eight data bits and one even-parity bit. The finished byte is presented with its parity bit and a parity-error flag, and a one-clock valid strobe marks it. If the start bit reads high at its middle sample, the frame is dropped and the receiver goes back to waiting for an edge.

Top module: `sc_rx_sampler`

## Requirements
- R1: After reset, `rx_byte`, `rx_par`, `par_err` and `byte_vld` are all 0 and the receiver is idle.
- R2: `ratio_sel` selects the bit period in ticks: 2'b00 = 32, 2'b01 = 64, 2'b10 = 372, 2'b11 = 256. A frame sent at the selected period is received correctly.
- R3: `rx_in` passes through two synchronizer flops. A start is recognised only while idle, on a tick where the synchronized line goes from 1 to 0, and that tick clears the phase counter to 0.
- R4: Bit b (0 = start) is sampled on the tick b*N + N/2 counted after the clearing tick. With `tick` held high, counting rising edges from the first one that sees `rx_in` low as edge 1, `byte_vld` is first high after edge 9*N + N/2 + 3.
- R5: The frame is one start bit of 0, then eight data bits with the LSB first, then one parity bit. `rx_byte` holds the data bits and `rx_par` holds the parity bit.
- R6: `byte_vld` is high for exactly one clock per accepted frame. `rx_byte`, `rx_par` and `par_err` keep their values until the next strobe.
- R7: `par_err` is 1 exactly when the number of ones across the eight data bits and the parity bit is odd. It changes only together with `byte_vld`.
- R8: A start bit that reads 1 at its middle sample drops the frame with no strobe. The next valid frame is still received.
- R9: `ratio_sel` is captured only while idle. Changing it during a frame does not affect that frame.
- R10: No internal state advances on a clock where `tick` is 0. With `tick` high every second clock, a frame lasting 2*N clocks per bit is received correctly. A frame sent while `tick` is held low produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Basic-clock enable, one pulse per basic-clock period |
| rx_in | input | 1 | Serial receive line, idle high |
| ratio_sel | input | 2 | Basic-clock to bit-rate ratio select |
| rx_byte | output | 8 | Last received data byte |
| rx_par | output | 1 | Last received parity bit |
| par_err | output | 1 | Even-parity check failed for the last byte |
| byte_vld | output | 1 | One-clock strobe when a character is complete |

## Verification
The embedded assertions check several properties on every cycle:
- the phase counter stays below the latched ratio;
- the latched ratio is frozen while a frame is in progress;
- nothing moves on a clock without `tick`;
- the strobe is a single clock wide;
- the error flag changes only with the strobe and matches the parity of the delivered bits;
- a high start-bit sample returns the receiver to idle.

Some behaviour can only be shown by the bench scenarios. These are:
- that each ratio code maps to the right bit period;
- the exact sampling latency from the line's falling edge;
- correct LSB-first assembly;
- recovery after a false start;
- reception with a gated tick.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

   localparam int FRAME_OVERHEAD = 2;   // start bit plus parity bit
   localparam int RATIO_CODES    = 4;

   typedef struct packed {
      logic [7:0] data;
      logic       par;
      logic       err;
   } rx_char_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx_in,
   output logic line_q,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sc_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              line_d;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic d_in;
      if (g == 0) begin : g_first
         assign d_in = rx_in;
      end else begin : g_next
         assign d_in = chain[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    chain[g] <= 1'b1;
         else if (tick) chain[g] <= d_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    line_d <= 1'b1;
      else if (tick) line_d <= chain[STAGES-1];
   end

   assign line_q = chain[STAGES-1];
   assign fall   = line_d & ~line_q;

   a_r10_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(line_q) && $stable(fall));

endmodule

// File: rtl/sc_rx_phase.sv
module sc_rx_phase #(
   parameter int RATIO_0 = 32,
   parameter int RATIO_1 = 64,
   parameter int RATIO_2 = 372,
   parameter int RATIO_3 = 256,
   parameter int LIM_W   = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       run,
   input  logic       start,
   input  logic [1:0] ratio_sel,
   output logic       mid_pulse
);

   localparam int RATIOS [sc_rx_pkg::RATIO_CODES] = '{RATIO_0, RATIO_1, RATIO_2, RATIO_3};

   logic [LIM_W-1:0] lim_tab [sc_rx_pkg::RATIO_CODES];
   logic [LIM_W-1:0] lim_q;
   logic [LIM_W-1:0] half_m1;
   logic [LIM_W-1:0] phase;

   for (genvar g = 0; g < sc_rx_pkg::RATIO_CODES; g++) begin : g_lim
      if (RATIOS[g] < 4 || (RATIOS[g] % 2) != 0) begin : g_bad_ratio
         $error("sc_rx_phase: each ratio must be even and at least 4");
      end
      if (RATIOS[g] >= (1 << LIM_W)) begin : g_bad_width
         $error("sc_rx_phase: LIM_W too narrow for ratio");
      end
      assign lim_tab[g] = LIM_W'(RATIOS[g]);
   end

   // ratio is latched while idle, frozen for the whole frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lim_q <= LIM_W'(RATIO_0);
      else if (!run) lim_q <= lim_tab[ratio_sel];
   end

   assign half_m1 = (lim_q >> 1) - LIM_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (start) begin
         phase <= '0;
      end else if (run && tick) begin
         if (phase == lim_q - LIM_W'(1)) phase <= '0;
         else                            phase <= phase + LIM_W'(1);
      end
   end

   assign mid_pulse = run && tick && (phase == half_m1);

   a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (phase < lim_q));

   a_r9_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(lim_q));

   a_r10_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase));

endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mid_pulse,
   input  logic              line_q,
   output logic              run,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_par,
   output logic              par_err,
   output logic              byte_vld
);

   localparam int FRAME_BITS = DATA_W + sc_rx_pkg::FRAME_OVERHEAD;
   localparam int BI_W       = $clog2(FRAME_BITS);

   if (DATA_W != 8) begin : g_bad_width
      $error("sc_rx_frame: character format carries eight data bits");
   end

   logic [BI_W-1:0]   bit_idx;
   logic [DATA_W:0]   sh;
   logic [DATA_W:0]   sh_next;
   logic              last_bit;
   logic              false_start;
   sc_rx_pkg::rx_char_t out_q;

   assign sh_next     = {line_q, sh[DATA_W:1]};
   assign last_bit    = (bit_idx == BI_W'(FRAME_BITS - 1));
   assign false_start = (bit_idx == '0) && line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         bit_idx  <= '0;
         sh       <= '0;
         out_q    <= '0;
         byte_vld <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (start) begin
            run     <= 1'b1;
            bit_idx <= '0;
         end else if (mid_pulse) begin
            if (false_start) begin
               run <= 1'b0;
            end else if (last_bit) begin
               run        <= 1'b0;
               out_q.data <= sh_next[DATA_W-1:0];
               out_q.par  <= line_q;
               out_q.err  <= ^sh_next;
               byte_vld   <= 1'b1;
            end else begin
               if (bit_idx != '0) sh <= sh_next;
               bit_idx <= bit_idx + BI_W'(1);
            end
         end
      end
   end

   assign rx_byte = out_q.data;
   assign rx_par  = out_q.par;
   assign par_err = out_q.err;

   a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

   a_r7_err_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(par_err) |-> byte_vld);

   a_r5_bit_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx < BI_W'(FRAME_BITS));

   a_r8_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_pulse && !start && bit_idx == '0 && line_q) |=> (!run && !byte_vld));

endmodule

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RATIO_0     = 32,
   parameter int RATIO_1     = 64,
   parameter int RATIO_2     = 372,
   parameter int RATIO_3     = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_in,
   input  logic [1:0]        ratio_sel,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_par,
   output logic              par_err,
   output logic              byte_vld
);

   localparam int MAX_R = sc_rx_pkg::max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3);
   localparam int LIM_W = $clog2(MAX_R + 1);

   logic line_q;
   logic fall;
   logic run;
   logic start;
   logic mid_pulse;

   sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .rx_in  (rx_in),
      .line_q (line_q),
      .fall   (fall)
   );

   assign start = fall && tick && !run;

   sc_rx_phase #(
      .RATIO_0 (RATIO_0),
      .RATIO_1 (RATIO_1),
      .RATIO_2 (RATIO_2),
      .RATIO_3 (RATIO_3),
      .LIM_W   (LIM_W)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .run       (run),
      .start     (start),
      .ratio_sel (ratio_sel),
      .mid_pulse (mid_pulse)
   );

   sc_rx_frame #(.DATA_W(DATA_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mid_pulse (mid_pulse),
      .line_q    (line_q),
      .run       (run),
      .rx_byte   (rx_byte),
      .rx_par    (rx_par),
      .par_err   (par_err),
      .byte_vld  (byte_vld)
   );

   a_r7_parity_match: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> (par_err == ^{rx_byte, rx_par}));

   a_r3_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !byte_vld) |-> !start);

endmodule

// File: tb/sim_sc_rx_sampler.sv
module sim_sc_rx_sampler;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       rx_in = 1'b1;
   logic [1:0] ratio_sel = 2'b00;
   logic [7:0] rx_byte;
   logic       rx_par;
   logic       par_err;
   logic       byte_vld;

   int compared = 0;
   int mismatched = 0;
   int tick_mode = 0;      // 0 always on, 1 every second clock, 2 held low
   int vld_seen = 0;
   int wide_vld = 0;
   logic prev_vld = 1'b0;
   logic [7:0] cap_byte = '0;
   logic cap_par = 1'b0;
   logic cap_err = 1'b0;

   always #4 clk = ~clk;

   sc_rx_sampler u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rx_in     (rx_in),
      .ratio_sel (ratio_sel),
      .rx_byte   (rx_byte),
      .rx_par    (rx_par),
      .par_err   (par_err),
      .byte_vld  (byte_vld)
   );

   always @(negedge clk) begin
      if (tick_mode == 1)      tick <= ~tick;
      else if (tick_mode == 2) tick <= 1'b0;
      else                     tick <= 1'b1;
      if (byte_vld) begin
         vld_seen++;
         cap_byte = rx_byte;
         cap_par  = rx_par;
         cap_err  = par_err;
      end
      if (byte_vld && prev_vld) wide_vld++;
      prev_vld = byte_vld;
   end

   function automatic int ratio_of(input logic [1:0] s);
      case (s)
         2'b00:   return 32;
         2'b01:   return 64;
         2'b10:   return 372;
         default: return 256;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge; drives one full frame then idle guard time
   task automatic send(input int n, input int div, input logic [7:0] d, input logic p);
      logic [9:0] bits;
      bits = {p, d, 1'b0};
      for (int b = 0; b < 10; b++) begin
         rx_in = bits[b];
         repeat (n * div) @(negedge clk);
      end
      rx_in = 1'b1;
      repeat (2 * n * div) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 rx_byte", rx_byte, 0);
      check("R1 rx_par", rx_par, 0);
      check("R1 par_err", par_err, 0);
      check("R1 byte_vld", byte_vld, 0);
   endtask

   task automatic t_ratio(input logic [1:0] s, input logic [7:0] d);
      vld_seen = 0;
      ratio_sel = s;
      send(ratio_of(s), 1, d, ^d);
      check("R2 strobes", vld_seen, 1);
      check("R5 data", cap_byte, d);
      check("R5 parity bit", cap_par, ^d);
      check("R7 no error", cap_err, 0);
      check("R6 held data", rx_byte, d);
   endtask

   task automatic t_latency(input logic [1:0] s);
      int n;
      int cnt;
      n = ratio_of(s);
      ratio_sel = s;
      cnt = 0;
      fork
         send(n, 1, 8'h5A, ^8'h5A);
         begin
            do begin
               @(posedge clk);
               cnt++;
               @(negedge clk);
            end while (!byte_vld && cnt < 12 * n);
         end
      join
      check("R4 latency", cnt, 9 * n + n / 2 + 3);
   endtask

   task automatic t_parity_err;
      vld_seen = 0;
      ratio_sel = 2'b00;
      send(32, 1, 8'hC3, 1'b1);   // four ones plus parity 1 -> odd
      check("R7 strobe", vld_seen, 1);
      check("R7 error set", cap_err, 1);
      check("R7 data", cap_byte, 8'hC3);
      check("R6 err held", par_err, 1);
   endtask

   task automatic t_false_start;
      vld_seen = 0;
      ratio_sel = 2'b01;
      rx_in = 1'b0;
      repeat (16) @(negedge clk);
      rx_in = 1'b1;
      repeat (3 * 64) @(negedge clk);
      check("R8 no strobe", vld_seen, 0);
      send(64, 1, 8'h81, ^8'h81);
      check("R8 recovery strobe", vld_seen, 1);
      check("R8 recovery data", cap_byte, 8'h81);
   endtask

   task automatic t_ratio_change;
      vld_seen = 0;
      ratio_sel = 2'b01;
      fork
         send(64, 1, 8'h3C, ^8'h3C);
         begin
            repeat (100) @(negedge clk);
            ratio_sel = 2'b00;
         end
      join
      check("R9 strobe", vld_seen, 1);
      check("R9 data", cap_byte, 8'h3C);
   endtask

   task automatic t_tick_gate;
      vld_seen = 0;
      ratio_sel = 2'b00;
      tick_mode = 1;
      send(32, 2, 8'hE7, ^8'hE7);
      check("R10 gated strobe", vld_seen, 1);
      check("R10 gated data", cap_byte, 8'hE7);
      vld_seen = 0;
      tick_mode = 2;
      repeat (2) @(negedge clk);
      send(32, 1, 8'h11, ^8'h11);
      check("R10 no tick no strobe", vld_seen, 0);
      tick_mode = 0;
      repeat (8) @(negedge clk);
      check("R10 data unchanged", rx_byte, 8'hE7);
   endtask

   initial begin
      #(8 * 200000);
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_ratio(2'b00, 8'hA5);
      t_ratio(2'b01, 8'h01);
      t_ratio(2'b10, 8'h80);
      t_ratio(2'b11, 8'hFF);
      t_ratio(2'b00, 8'h00);
      t_latency(2'b10);
      t_latency(2'b00);
      t_parity_err;
      t_false_start;
      t_ratio_change;
      t_tick_gate;
      check("R6 strobe width", wide_vld, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule